// File: doc/BRIEF.md
# Accumulator Instruction Execute Unit

This block decodes and executes one 14-bit instruction word per clock for an accumulator machine. The machine has a working register W and a register file addressed with 7 bits. Each word belongs to one of four classes: byte operations on a file register, single-bit operations on a file register, jumps, and operations with an 8-bit literal. The unit holds W and the carry (C), digit carry (DC) and zero (Z) flags itself. For byte operations a destination bit sends the result either to W or back to the addressed file register. Each operation updates its own subset of the flags.

The file register is read at the address carried in the low seven bits of the word, and its data returns in the same cycle. When a conditional test is true, or when the word changes the program counter (jump, call or return), the unit raises a redirect request. The next word then runs as a flushed cycle: it writes nothing, requests nothing, and leaves W and the flags as they were. The program counter, the return stack, program memory, interrupts and power modes are all outside this block. The unit only signals jump targets, pushes and pops to them.

Top module: `acc_exec_unit`

## Requirements
- R1: While rst_ni is low, and after it rises, W, C, DC, Z and the flushed-cycle state are all zero.
- R2: Byte operations have the form 00 oooo d fffffff. With d=1 the result goes to file address f (f_we_o high, data on f_wdata_o). With d=0 the result goes to W and no file write occurs. MOVWF (oooo=0000, d=1) writes W to f. Both destinations are never written in one cycle.
- R3: ADDWF (0111), SUBWF (0010), ADDLW (literal bits 13:9 = 11111) and SUBLW (11110) compute operand+W and operand+~W+1. C is the carry out of bit 7, so C=1 on a subtraction means no borrow. DC is the carry out of bit 3. Z is set when the 8-bit result is zero.
- R4: ANDWF (0101), IORWF (0100), XORWF (0110), COMF (1001), INCF (1010), DECF (0011), MOVF (1000) and the clear ops (0001: d=1 clears f, d=0 clears W) update only Z. C and DC keep their values.
- R5: RLF (1101) and RRF (1100) rotate the 8-bit operand and C together as a 9-bit ring. They update only C.
- R6: SWAPF (1110) exchanges the operand's nibbles. SWAPF, MOVWF, all bit operations, DECFSZ and INCFSZ leave C, DC and Z unchanged.
- R7: Bit operations have the form 01 oo bbb fffffff. oo=00 clears bit b of f and oo=01 sets it. The byte is written back to f, and only bit b differs from the value read.
- R8: A redirect is requested in these cases: DECFSZ (1011) or INCFSZ (1111) when its result is zero; oo=10 when bit b is clear; oo=11 when bit b is set. The two test forms write nothing.
- R9: Bits 13:11 = 100 is a call and 101 is a jump. Both assert jump_o and redirect_o, with the target taken from bits 10:0; only the call asserts push_o. Words 0x0008 and 0x0009 (returns) and literal form 1101xx (return with literal) assert pop_o and redirect_o. The literal return also loads k into W.
- R10: The cycle after any redirect is flushed. flush_o is high, there is no file write and no redirect, jump, push or pop, and W and the flags are unchanged.
- R11: MOVLW (literal bits 13:10 = 1100) loads k into W and changes no flag. IORLW (111000), ANDLW (111001) and XORLW (111010) combine k with W and update only Z.
- R12: Words 0x0000, 0x0063 and 0x0064, and the unused literal form 111011, have no effect: no write, no request, and W and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 14 | Instruction word executed this cycle |
| f_rdata_i | input | 8 | File register data at f_addr_o |
| f_addr_o | output | 7 | File register address |
| f_we_o | output | 1 | File register write enable |
| f_wdata_o | output | 8 | File register write data |
| w_o | output | 8 | Working register W |
| c_o | output | 1 | Carry flag |
| dc_o | output | 1 | Digit carry flag |
| z_o | output | 1 | Zero flag |
| flush_o | output | 1 | The current word is squashed |
| redirect_o | output | 1 | Next word must be squashed (skip or program counter change) |
| jump_o | output | 1 | Load program counter from jump_addr_o |
| jump_addr_o | output | 11 | Jump or call target |
| push_o | output | 1 | Push return address (call) |
| pop_o | output | 1 | Pop return address (returns) |

## Verification
The bench targets the edges of the arithmetic. It runs an add that carries out of both bit 3 and bit 7 to give a zero result, and a subtraction that borrows. If the borrow sense of C is inverted, or DC is taken from the wrong bit, these flag values come out wrong. It also runs increment and decrement wrapping to zero, which must not touch C, and rotations that must pass C through bit 0 and bit 7. Skips are tested on both outcomes, including DECFSZ with Z initially clear, so a design that also updated Z on a skip op would be caught. Flushed cycles are loaded with words that would otherwise write, skip or jump; a design that still acted on them would show a write, a second redirect or a changed W.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int INSTR_W = 14;
  localparam int DATA_W  = 8;
  localparam int FADDR_W = 7;
  localparam int JUMP_W  = 11;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int NIB_W   = DATA_W / 2;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC, OP_DEC,
    OP_MOVA, OP_CLR, OP_RLF, OP_RRF, OP_SWAP, OP_BCLR, OP_BSET, OP_MOVW
  } alu_op_e;

  typedef enum logic [1:0] {SK_NONE, SK_ZERO, SK_BITCLR, SK_BITSET} skip_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_lit;
    logic    wr_f;
    logic    wr_w;
    logic    upd_c;
    logic    upd_dc;
    logic    upd_z;
    skip_e   skip;
    logic    jump;
    logic    push;
    logic    pop;
  } dec_t;
endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [3:0] nib;
  logic       dst_f;

  assign nib   = instr_i[11:8];
  assign dst_f = instr_i[FADDR_W];

  always_comb begin
    dec_o = '{op: OP_NONE, use_lit: 1'b0, wr_f: 1'b0, wr_w: 1'b0, upd_c: 1'b0,
              upd_dc: 1'b0, upd_z: 1'b0, skip: SK_NONE, jump: 1'b0, push: 1'b0,
              pop: 1'b0};
    unique case (instr_i[13:12])
      2'b00: begin
        // byte class: result destination picked by d
        dec_o.wr_f = dst_f;
        dec_o.wr_w = !dst_f;
        unique case (nib)
          4'b0000: begin
            dec_o.wr_w = 1'b0;
            if (dst_f) begin
              dec_o.op = OP_MOVW;
            end else begin
              dec_o.wr_f = 1'b0;
              // fixed control words; only the two returns act here
              if (instr_i[6:0] == 7'h08 || instr_i[6:0] == 7'h09) dec_o.pop = 1'b1;
            end
          end
          4'b0001: begin dec_o.op = OP_CLR;  dec_o.upd_z = 1'b1; end
          4'b0010: begin dec_o.op = OP_SUB;  dec_o.upd_c = 1'b1; dec_o.upd_dc = 1'b1; dec_o.upd_z = 1'b1; end
          4'b0111: begin dec_o.op = OP_ADD;  dec_o.upd_c = 1'b1; dec_o.upd_dc = 1'b1; dec_o.upd_z = 1'b1; end
          4'b0101: begin dec_o.op = OP_AND;  dec_o.upd_z = 1'b1; end
          4'b0100: begin dec_o.op = OP_IOR;  dec_o.upd_z = 1'b1; end
          4'b0110: begin dec_o.op = OP_XOR;  dec_o.upd_z = 1'b1; end
          4'b1001: begin dec_o.op = OP_COM;  dec_o.upd_z = 1'b1; end
          4'b0011: begin dec_o.op = OP_DEC;  dec_o.upd_z = 1'b1; end
          4'b1010: begin dec_o.op = OP_INC;  dec_o.upd_z = 1'b1; end
          4'b1000: begin dec_o.op = OP_MOVA; dec_o.upd_z = 1'b1; end
          4'b1011: begin dec_o.op = OP_DEC;  dec_o.skip = SK_ZERO; end
          4'b1111: begin dec_o.op = OP_INC;  dec_o.skip = SK_ZERO; end
          4'b1100: begin dec_o.op = OP_RRF;  dec_o.upd_c = 1'b1; end
          4'b1101: begin dec_o.op = OP_RLF;  dec_o.upd_c = 1'b1; end
          4'b1110: begin dec_o.op = OP_SWAP; end
          default: ;
        endcase
      end
      2'b01: begin
        unique case (instr_i[11:10])
          2'b00: begin dec_o.op = OP_BCLR; dec_o.wr_f = 1'b1; end
          2'b01: begin dec_o.op = OP_BSET; dec_o.wr_f = 1'b1; end
          2'b10: dec_o.skip = SK_BITCLR;
          default: dec_o.skip = SK_BITSET;
        endcase
      end
      2'b10: begin
        dec_o.jump = 1'b1;
        dec_o.push = !instr_i[11];
      end
      default: begin
        dec_o.use_lit = 1'b1;
        casez (nib)
          4'b00??: begin dec_o.op = OP_MOVA; dec_o.wr_w = 1'b1; end
          4'b01??: begin dec_o.op = OP_MOVA; dec_o.wr_w = 1'b1; dec_o.pop = 1'b1; end
          4'b1000: begin dec_o.op = OP_IOR;  dec_o.wr_w = 1'b1; dec_o.upd_z = 1'b1; end
          4'b1001: begin dec_o.op = OP_AND;  dec_o.wr_w = 1'b1; dec_o.upd_z = 1'b1; end
          4'b1010: begin dec_o.op = OP_XOR;  dec_o.wr_w = 1'b1; dec_o.upd_z = 1'b1; end
          4'b110?: begin
            dec_o.op = OP_SUB; dec_o.wr_w = 1'b1;
            dec_o.upd_c = 1'b1; dec_o.upd_dc = 1'b1; dec_o.upd_z = 1'b1;
          end
          4'b111?: begin
            dec_o.op = OP_ADD; dec_o.wr_w = 1'b1;
            dec_o.upd_c = 1'b1; dec_o.upd_dc = 1'b1; dec_o.upd_z = 1'b1;
          end
          default: ;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic              c_i,
  input  logic [BIT_W-1:0]  bsel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              dc_o
);
  logic [DATA_W-1:0] bop;
  logic              cin;
  logic [NIB_W:0]    lo_sum;
  logic [DATA_W:0]   full_sum;
  logic [DATA_W-1:0] mask;

  // subtract as operand + ~W + 1 so C reads as "no borrow"
  assign bop      = (op_i == OP_SUB) ? ~w_i : w_i;
  assign cin      = (op_i == OP_SUB);
  assign lo_sum   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, bop[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  assign full_sum = {1'b0, a_i} + {1'b0, bop} + {{DATA_W{1'b0}}, cin};

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (bsel_i == BIT_W'(i));
  end

  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    dc_o  = lo_sum[NIB_W];
    unique case (op_i)
      OP_ADD, OP_SUB: begin res_o = full_sum[DATA_W-1:0]; c_o = full_sum[DATA_W]; end
      OP_AND:  res_o = a_i & w_i;
      OP_IOR:  res_o = a_i | w_i;
      OP_XOR:  res_o = a_i ^ w_i;
      OP_COM:  res_o = ~a_i;
      OP_INC:  res_o = a_i + DATA_W'(1);
      OP_DEC:  res_o = a_i - DATA_W'(1);
      OP_CLR:  res_o = '0;
      OP_RLF:  begin res_o = {a_i[DATA_W-2:0], c_i}; c_o = a_i[DATA_W-1]; end
      OP_RRF:  begin res_o = {c_i, a_i[DATA_W-1:1]}; c_o = a_i[0]; end
      OP_SWAP: res_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
      OP_BCLR: res_o = a_i & ~mask;
      OP_BSET: res_o = a_i | mask;
      OP_MOVW: res_o = w_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  f_rdata_i,
  output logic [FADDR_W-1:0] f_addr_o,
  output logic               f_we_o,
  output logic [DATA_W-1:0]  f_wdata_o,
  output logic [DATA_W-1:0]  w_o,
  output logic               c_o,
  output logic               dc_o,
  output logic               z_o,
  output logic               flush_o,
  output logic               redirect_o,
  output logic               jump_o,
  output logic [JUMP_W-1:0]  jump_addr_o,
  output logic               push_o,
  output logic               pop_o
);
  dec_t              dec;
  logic [DATA_W-1:0] w_q, operand, res;
  logic              c_q, dc_q, z_q, squash_q;
  logic              c_new, dc_new, live, w_we, bit_val, skip_hit;
  logic [BIT_W-1:0]  bsel;

  acc_exec_decode u_decode (.instr_i(instr_i), .dec_o(dec));

  assign bsel    = instr_i[FADDR_W +: BIT_W];
  assign operand = dec.use_lit ? instr_i[DATA_W-1:0] : f_rdata_i;

  acc_exec_alu u_alu (
    .op_i(dec.op), .a_i(operand), .w_i(w_q), .c_i(c_q), .bsel_i(bsel),
    .res_o(res), .c_o(c_new), .dc_o(dc_new)
  );

  assign live    = !squash_q;
  assign bit_val = f_rdata_i[bsel];

  always_comb begin
    unique case (dec.skip)
      SK_ZERO:   skip_hit = (res == '0);
      SK_BITCLR: skip_hit = !bit_val;
      SK_BITSET: skip_hit = bit_val;
      default:   skip_hit = 1'b0;
    endcase
  end

  assign w_we        = live && dec.wr_w;
  assign f_we_o      = live && dec.wr_f;
  assign f_wdata_o   = res;
  assign f_addr_o    = instr_i[FADDR_W-1:0];
  assign jump_o      = live && dec.jump;
  assign push_o      = live && dec.push;
  assign pop_o       = live && dec.pop;
  assign jump_addr_o = instr_i[JUMP_W-1:0];
  assign redirect_o  = live && (skip_hit || dec.jump || dec.pop);
  assign flush_o     = squash_q;
  assign w_o  = w_q;
  assign c_o  = c_q;
  assign dc_o = dc_q;
  assign z_o  = z_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q      <= '0;
      c_q      <= 1'b0;
      dc_q     <= 1'b0;
      z_q      <= 1'b0;
      squash_q <= 1'b0;
    end else begin
      squash_q <= redirect_o;
      if (w_we) w_q <= res;
      if (live && dec.upd_c)  c_q  <= c_new;
      if (live && dec.upd_dc) dc_q <= dc_new;
      if (live && dec.upd_z)  z_q  <= (res == '0);
    end
  end

  assert_one_dest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({f_we_o, w_we}));

  assert_rot_c_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && instr_i[13:9] == 5'b00110) |=> $stable({dc_o, z_o}));

  assert_bitop_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && instr_i[13:12] == 2'b01) |=> $stable({c_o, dc_o, z_o}));

  assert_bit_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && instr_i[13:11] == 3'b010) |-> ($countones(f_wdata_o ^ f_rdata_i) <= 1));

  assert_push_is_jump_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (jump_o && redirect_o));

  assert_redirect_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> flush_o);

  assert_flush_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (!f_we_o && !redirect_o && !jump_o && !pop_o));

  assert_flush_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> $stable({w_o, c_o, dc_o, z_o}));
endmodule

// File: tb/acc_exec_unit_bench.sv
module acc_exec_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0]  fdat = '0;
  logic [6:0]  f_addr_o;
  logic        f_we_o, c_o, dc_o, z_o, flush_o, redirect_o, jump_o, push_o, pop_o;
  logic [7:0]  f_wdata_o, w_o;
  logic [10:0] jump_addr_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        s_we, s_rd, s_jmp, s_push, s_pop, s_fl;
  logic [7:0]  s_wd;
  logic [6:0]  s_addr;
  logic [10:0] s_ja;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_exec_unit u_acc_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .f_rdata_i(fdat),
    .f_addr_o(f_addr_o), .f_we_o(f_we_o), .f_wdata_o(f_wdata_o), .w_o(w_o),
    .c_o(c_o), .dc_o(dc_o), .z_o(z_o), .flush_o(flush_o), .redirect_o(redirect_o),
    .jump_o(jump_o), .jump_addr_o(jump_addr_o), .push_o(push_o), .pop_o(pop_o)
  );

  function automatic logic [13:0] byte_op(input logic [3:0] nib, input logic d, input logic [6:0] f);
    return {2'b00, nib, d, f};
  endfunction
  function automatic logic [13:0] bit_op(input logic [1:0] sub, input logic [2:0] b, input logic [6:0] f);
    return {2'b01, sub, b, f};
  endfunction
  function automatic logic [13:0] lit(input logic [5:0] top, input logic [7:0] k);
    return {top, k};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic c, input logic dc, input logic z);
    chk(tag, {29'd0, c_o, dc_o, z_o}, {29'd0, c, dc, z});
  endtask

  // present a word for one cycle; capture combinational outputs, then let the edge pass
  task automatic step(input logic [13:0] ins, input logic [7:0] fd);
    @(negedge clk);
    instr = ins; fdat = fd;
    #1;
    s_we = f_we_o; s_wd = f_wdata_o; s_addr = f_addr_o; s_rd = redirect_o;
    s_jmp = jump_o; s_ja = jump_addr_o; s_push = push_o; s_pop = pop_o; s_fl = flush_o;
    @(posedge clk);
    #1;
  endtask

  task automatic flush_step(input string tag);
    step(14'h0000, 8'h00);
    chk({tag, " flushed"}, 32'(s_fl), 1);
  endtask

  task automatic t_reset();
    instr = 14'h0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 w in reset", 32'(w_o), 0);
    chk_flags("R1 flags in reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 flush after reset", 32'(flush_o), 0);
    chk("R1 no write after reset", 32'(f_we_o), 0);
    chk("R1 w after reset", 32'(w_o), 0);
  endtask

  task automatic t_add_sub();
    step(lit(6'h30, 8'h38), 8'h00);
    chk("R11 movlw w", 32'(w_o), 32'h38);
    chk_flags("R11 movlw flags", 0, 0, 0);
    step(byte_op(4'h7, 1'b0, 7'h10), 8'h08);
    chk("R2 addwf d0 no file write", 32'(s_we), 0);
    chk("R3 addwf w", 32'(w_o), 32'h40);
    chk_flags("R3 addwf dc", 0, 1, 0);
    step(lit(6'h3E, 8'hC0), 8'h00);
    chk("R3 addlw wrap", 32'(w_o), 0);
    chk_flags("R3 addlw carry zero", 1, 0, 1);
    step(lit(6'h30, 8'h05), 8'h00);
    step(byte_op(4'h2, 1'b1, 7'h20), 8'h03);
    chk("R2 subwf d1 write", 32'(s_we), 1);
    chk("R2 subwf addr", 32'(s_addr), 32'h20);
    chk("R3 subwf borrow data", 32'(s_wd), 32'hFE);
    chk("R2 subwf w kept", 32'(w_o), 32'h05);
    chk_flags("R3 subwf borrow flags", 0, 0, 0);
    step(lit(6'h3C, 8'h05), 8'h00);
    chk("R3 sublw equal", 32'(w_o), 0);
    chk_flags("R3 sublw no borrow", 1, 1, 1);
  endtask

  task automatic t_logic();
    step(lit(6'h30, 8'hF0), 8'h00);
    chk_flags("R11 movlw keeps flags", 1, 1, 1);
    step(byte_op(4'h5, 1'b0, 7'h01), 8'h0F);
    chk("R4 andwf w", 32'(w_o), 0);
    chk_flags("R4 andwf z only", 1, 1, 1);
    step(lit(6'h3A, 8'hFF), 8'h00);
    chk("R11 xorlw w", 32'(w_o), 32'hFF);
    chk_flags("R11 xorlw z only", 1, 1, 0);
    step(byte_op(4'h4, 1'b1, 7'h02), 8'h00);
    chk("R4 iorwf data", 32'(s_wd), 32'hFF);
    chk_flags("R4 iorwf flags", 1, 1, 0);
    step(byte_op(4'h9, 1'b0, 7'h03), 8'hFF);
    chk("R4 comf w", 32'(w_o), 0);
    chk_flags("R4 comf flags", 1, 1, 1);
    step(byte_op(4'h6, 1'b0, 7'h03), 8'h3C);
    chk("R4 xorwf w", 32'(w_o), 32'h3C);
    chk_flags("R4 xorwf flags", 1, 1, 0);
    step(byte_op(4'hA, 1'b1, 7'h04), 8'hFF);
    chk("R4 incf wrap data", 32'(s_wd), 0);
    chk_flags("R4 incf no carry", 1, 1, 1);
    step(byte_op(4'h3, 1'b0, 7'h05), 8'h01);
    chk("R4 decf w", 32'(w_o), 0);
    chk_flags("R4 decf flags", 1, 1, 1);
    step(byte_op(4'h8, 1'b0, 7'h06), 8'h80);
    chk("R4 movf w", 32'(w_o), 32'h80);
    chk_flags("R4 movf flags", 1, 1, 0);
    step(byte_op(4'h1, 1'b1, 7'h07), 8'h55);
    chk("R4 clrf write", 32'({s_we, s_wd}), 32'h100);
    chk("R4 clrf w kept", 32'(w_o), 32'h80);
    chk_flags("R4 clrf flags", 1, 1, 1);
    step(lit(6'h30, 8'h44), 8'h00);
    step(byte_op(4'h1, 1'b0, 7'h07), 8'h55);
    chk("R4 clrw no write", 32'(s_we), 0);
    chk("R4 clrw w", 32'(w_o), 0);
    step(lit(6'h38, 8'h21), 8'h00);
    chk("R11 iorlw w", 32'(w_o), 32'h21);
    chk_flags("R11 iorlw flags", 1, 1, 0);
    step(lit(6'h39, 8'h02), 8'h00);
    chk("R11 andlw w", 32'(w_o), 0);
    chk_flags("R11 andlw flags", 1, 1, 1);
  endtask

  task automatic t_rotate();
    step(lit(6'h30, 8'h80), 8'h00);
    step(lit(6'h3E, 8'h80), 8'h00);
    chk_flags("R3 addlw carry set", 1, 0, 1);
    step(byte_op(4'hD, 1'b0, 7'h08), 8'h81);
    chk("R5 rlf w", 32'(w_o), 32'h03);
    chk_flags("R5 rlf c only", 1, 0, 1);
    step(byte_op(4'hC, 1'b1, 7'h09), 8'h02);
    chk("R5 rrf data", 32'(s_wd), 32'h81);
    chk_flags("R5 rrf c out", 0, 0, 1);
    step(byte_op(4'hD, 1'b1, 7'h09), 8'h7F);
    chk("R5 rlf zero carry in", 32'(s_wd), 32'hFE);
    chk_flags("R5 rlf c clear", 0, 0, 1);
    step(byte_op(4'hC, 1'b0, 7'h09), 8'h01);
    chk("R5 rrf to zero", 32'(w_o), 0);
    chk_flags("R5 rrf c set z kept", 1, 0, 1);
  endtask

  task automatic t_swap_move();
    step(byte_op(4'hE, 1'b0, 7'h0A), 8'hA5);
    chk("R6 swapf w", 32'(w_o), 32'h5A);
    chk_flags("R6 swapf flags", 1, 0, 1);
    step(byte_op(4'h0, 1'b1, 7'h33), 8'h00);
    chk("R2 movwf write", 32'({s_we, s_addr, s_wd}), {17'd0, 1'b1, 7'h33, 8'h5A});
    chk_flags("R6 movwf flags", 1, 0, 1);
  endtask

  task automatic t_bits();
    step(bit_op(2'b00, 3'd3, 7'h11), 8'hFF);
    chk("R7 bcf data", 32'({s_we, s_wd}), 32'h1F7);
    step(bit_op(2'b01, 3'd7, 7'h12), 8'h00);
    chk("R7 bsf data", 32'({s_we, s_wd}), 32'h180);
    chk_flags("R6 bit ops flags", 1, 0, 1);
    step(bit_op(2'b10, 3'd0, 7'h13), 8'h01);
    chk("R8 btfsc bit set no skip", 32'({s_we, s_rd}), 0);
    step(bit_op(2'b10, 3'd0, 7'h13), 8'h00);
    chk("R8 btfsc bit clear skip", 32'({s_we, s_rd}), 1);
    flush_step("R10 after btfsc");
    step(bit_op(2'b11, 3'd6, 7'h14), 8'h40);
    chk("R8 btfss bit set skip", 32'({s_we, s_rd}), 1);
    flush_step("R10 after btfss");
    step(bit_op(2'b11, 3'd6, 7'h14), 8'h00);
    chk("R8 btfss bit clear no skip", 32'(s_rd), 0);
    chk_flags("R6 bit tests flags", 1, 0, 1);
  endtask

  task automatic t_skip_count();
    step(lit(6'h30, 8'h00), 8'h00);
    step(lit(6'h38, 8'h01), 8'h00);
    chk_flags("R11 iorlw clears z", 1, 0, 0);
    step(byte_op(4'hB, 1'b1, 7'h15), 8'h01);
    chk("R8 decfsz zero data", 32'({s_we, s_wd}), 32'h100);
    chk("R8 decfsz skip", 32'(s_rd), 1);
    flush_step("R10 after decfsz");
    chk_flags("R6 decfsz flags", 1, 0, 0);
    step(byte_op(4'hF, 1'b0, 7'h16), 8'h05);
    chk("R8 incfsz no skip", 32'(s_rd), 0);
    chk("R8 incfsz w", 32'(w_o), 32'h06);
    step(byte_op(4'hF, 1'b1, 7'h16), 8'hFF);
    chk("R8 incfsz wrap skip", 32'({s_rd, s_wd}), 32'h100);
    flush_step("R10 after incfsz");
    chk_flags("R6 incfsz flags", 1, 0, 0);
  endtask

  task automatic t_flush();
    step(lit(6'h30, 8'h11), 8'h00);
    step({3'b101, 11'h123}, 8'h00);
    chk("R9 goto jump", 32'({s_jmp, s_push, s_rd}), 32'b101);
    chk("R9 goto target", 32'(s_ja), 32'h123);
    step(byte_op(4'h7, 1'b1, 7'h01), 8'h01);
    chk("R10 flushed add", 32'({s_fl, s_we, s_rd}), 32'b100);
    chk("R10 flushed w kept", 32'(w_o), 32'h11);
    chk_flags("R10 flushed flags kept", 1, 0, 0);
    step(bit_op(2'b11, 3'd0, 7'h02), 8'h01);
    chk("R10 word after flush runs", 32'({s_fl, s_rd}), 32'b01);
    step({3'b101, 11'h055}, 8'h00);
    chk("R10 jump squashed", 32'({s_fl, s_jmp, s_rd, s_pop}), 32'b1000);
    step(lit(6'h30, 8'h22), 8'h00);
    chk("R10 no flush after squashed jump", 32'(s_fl), 0);
    chk("R10 movlw after flush", 32'(w_o), 32'h22);
  endtask

  task automatic t_call_ret();
    step({3'b100, 11'h7FF}, 8'h00);
    chk("R9 call signals", 32'({s_jmp, s_push, s_pop, s_rd}), 32'b1101);
    chk("R9 call target", 32'(s_ja), 32'h7FF);
    flush_step("R10 after call");
    step(14'h0008, 8'h00);
    chk("R9 return pop", 32'({s_jmp, s_push, s_pop, s_rd}), 32'b0011);
    flush_step("R10 after return");
    step(14'h0009, 8'h00);
    chk("R9 retfie pop", 32'({s_pop, s_rd}), 32'b11);
    flush_step("R10 after retfie");
    step(lit(6'h34, 8'h42), 8'h00);
    chk("R9 retlw pop", 32'({s_pop, s_rd, s_we}), 32'b110);
    chk("R9 retlw w", 32'(w_o), 32'h42);
    flush_step("R10 after retlw");
  endtask

  task automatic t_nop_words();
    logic [13:0] words [4];
    words[0] = 14'h0000; words[1] = 14'h0064; words[2] = 14'h0063; words[3] = lit(6'h3B, 8'h55);
    for (int i = 0; i < 4; i++) begin
      step(words[i], 8'hAA);
      chk("R12 no action", 32'({s_we, s_rd, s_jmp, s_pop, s_push}), 0);
      chk("R12 w kept", 32'(w_o), 32'h42);
      chk_flags("R12 flags kept", 1, 0, 0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    t_reset();
    t_add_sub();
    t_logic();
    t_rotate();
    t_swap_move();
    t_bits();
    t_skip_count();
    t_flush();
    t_call_ret();
    t_nop_words();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule